// File: doc/BRIEF.md
# PWM Timer Channel with Clean 0% and 100% Duty

This block is a single pulse-width modulation channel built around a free-running up-counter. The counter steps from zero to a programmable modulo value on each enabled clock and then wraps to zero. The wrap is the overflow event. A compare match happens on the clock edge at which the counter moves to the compare value. The channel output toggles on each overflow and is forced to a programmed level on each compare match. Together these give a PWM waveform whose period is modulo + 1 counts.

An 8-bit control register sets up the channel:
- an event flag, with an interrupt enable;
- two stored mode bits;
- two output-level select bits;
- a toggle-on-overflow enable;
- a maximum-duty bit.

Clearing the toggle enable gives a steady 0% output. Setting the maximum-duty bit gives a steady 100% output. Both controls act at period boundaries, so the output never glitches in the middle of a period. When an overflow and a compare fall on the same edge, the overflow decides the output.

Top module: `pwm_duty_channel`

## Requirements
- R1: While `cnt_en` is high the counter steps by one per clock from 0 up to `mod_val` and then returns to 0. If the count is already above `mod_val`, it also returns to 0. While `cnt_en` is low the counter holds its value.
- R2: In normal operation, each overflow (count equal to `mod_val` while enabled) toggles the internal pin state when the toggle enable (bit 1) is 1. Each compare match (the next count equals `cmp_val`) forces the pin to the compare level. The level-select field is bits 3:2. The value 2'b10 gives a compare level of low. The values 2'b01 and 2'b11 give a compare level of high. The active level is the inverse of the compare level.
- R3: When an overflow and a compare match occur on the same edge, the overflow action applies and the compare is ignored. With `cmp_val` = 0 and toggling enabled, the output therefore holds for a whole period and inverts at each wrap. This is 50% duty at twice the counter period.
- R4: At each overflow edge, the toggle enable applies as the register holds it at that edge. If the bit is cleared, the pin no longer toggles and compares keep forcing the compare level, which gives 0% duty from the next period. Setting the bit again restores PWM from the next period.
- R5: Register layout, from bit 7 down to bit 0: event flag, interrupt enable, mode bit B, mode bit A, level select B, level select A, toggle enable, maximum duty. All bits reset to 0. Bits 6:0 read back as they were written.
- R6: After the maximum-duty bit is set, the next overflow drives the pin to the active level. From then on, every overflow and compare leaves the pin unchanged, which gives 100% duty.
- R7: After the maximum-duty bit is cleared, the first overflow leaves the pin unchanged. Later compares and overflows act normally again.
- R8: A write to the maximum-duty bit does not change the current period. A compare that follows the setting write in the same period still forces the compare level. A compare that follows the clearing write in the same period is still blocked.
- R9: When level select is 2'b00, `pwm_out` is held at 0.
- R10: The event flag sets on every overflow and every compare match. It clears only when a write with bit 7 = 0 follows a read that saw the flag at 1. A write of 1 to bit 7 has no effect, and so does a write of 0 without that prior read.
- R11: `irq` is high exactly when both the event flag and the interrupt enable are 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cnt_en | input | 1 | Counter step enable |
| mod_val | input | CNT_W | Counter modulo (last count) |
| cmp_val | input | CNT_W | Compare value |
| ctl_wr | input | 1 | Control register write strobe |
| ctl_wdata | input | 8 | Control register write data |
| ctl_rd | input | 1 | Control register read strobe (arms flag clear) |
| ctl_rdata | output | 8 | Control register contents |
| count | output | CNT_W | Current counter value |
| pwm_out | output | 1 | Channel output |
| irq | output | 1 | Channel interrupt request |

## Verification
The overflow toggle and the compare action can land on the same clock edge. The bench provokes this by setting the compare value to zero. It then judges the result by sampling the output at count 0 and count 2 over three periods: the level must stay constant within each period and invert at each wrap. A second source of coincidence is the edge at which a period-boundary control change is applied. The bench times writes of the toggle enable and the maximum-duty bit to a known count. It then checks the output at the compare point of the same period and at the following overflow.

// File: rtl/pwm_duty_channel.sv
module pwm_duty_channel #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cnt_en,
  input  logic [CNT_W-1:0] mod_val,
  input  logic [CNT_W-1:0] cmp_val,
  input  logic             ctl_wr,
  input  logic [7:0]       ctl_wdata,
  input  logic             ctl_rd,
  output logic [7:0]       ctl_rdata,
  output logic [CNT_W-1:0] count,
  output logic             pwm_out,
  output logic             irq
);

  logic [6:0]       cfg;
  logic             flag, clr_arm;
  logic             max_sh, pin_q;
  logic [CNT_W-1:0] cnt_nxt;
  logic             ovf, hit, evt, flag_clr;
  logic             cmp_lvl;

  wire ie      = cfg[6];
  wire [1:0] lsel = cfg[3:2];
  wire tog_en  = cfg[1];
  wire max_req = cfg[0];

  assign ovf      = cnt_en && (count >= mod_val);
  assign cnt_nxt  = ovf ? '0 : count + 1'b1;
  assign hit      = cnt_en && (cnt_nxt == cmp_val);
  assign evt      = ovf || hit;
  assign cmp_lvl  = lsel[0];
  assign flag_clr = ctl_wr && !ctl_wdata[7] && clr_arm;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) count <= '0;
    else if (cnt_en) count <= cnt_nxt;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg     <= '0;
      flag    <= 1'b0;
      clr_arm <= 1'b0;
    end else begin
      if (ctl_wr) cfg <= ctl_wdata[6:0];
      if (evt) flag <= 1'b1;
      else if (flag_clr) flag <= 1'b0;
      if (ctl_wr) clr_arm <= 1'b0;
      else if (ctl_rd && flag) clr_arm <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      max_sh <= 1'b0;
      pin_q  <= 1'b0;
    end else if (ovf) begin
      max_sh <= max_req;
      if (max_req && !max_sh) pin_q <= ~cmp_lvl;
      else if (!max_sh && !max_req && tog_en) pin_q <= ~pin_q;
    end else if (hit && !max_sh) begin
      pin_q <= cmp_lvl;
    end
  end

  assign pwm_out   = (lsel == 2'b00) ? 1'b0 : pin_q;
  assign ctl_rdata = {flag, cfg};
  assign irq       = flag && ie;

  // R1
  wrap_to_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ovf |=> (count == '0));

  // R3
  ovf_beats_cmp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf && hit && !max_sh && !max_req && tog_en) |=> (pin_q != $past(pin_q)));

  // R4
  no_toggle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf && !tog_en && !max_sh && !max_req) |=> $stable(pin_q));

  // R6
  max_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf && max_req && !max_sh) |=> (pin_q == !$past(cmp_lvl)));

  // R6
  max_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (max_sh && max_req) |=> $stable(pin_q));

  // R7
  max_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf && max_sh && !max_req) |=> $stable(pin_q));

  // R10
  flag_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    evt |=> flag);

  // R10
  flag_w1_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_wr && ctl_wdata[7] && !flag && !evt) |=> !flag);

endmodule

// File: tb/pwm_duty_channel_tb.sv
module pwm_duty_channel_tb;
  localparam int CLK_PERIOD = 10;
  localparam int W = 8;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         cnt_en = 1'b0;
  logic [W-1:0] mod_val = 8'd3;
  logic [W-1:0] cmp_val = 8'd2;
  logic         ctl_wr = 1'b0;
  logic [7:0]   ctl_wdata = '0;
  logic         ctl_rd = 1'b0;
  logic [7:0]   ctl_rdata;
  logic [W-1:0] count;
  logic         pwm_out, irq;

  int total = 0;
  int bad = 0;
  bit done = 0;

  pwm_duty_channel #(.CNT_W(W)) u_dut (
    .clk(clk), .rst_n(rst_n), .cnt_en(cnt_en), .mod_val(mod_val),
    .cmp_val(cmp_val), .ctl_wr(ctl_wr), .ctl_wdata(ctl_wdata),
    .ctl_rd(ctl_rd), .ctl_rdata(ctl_rdata), .count(count),
    .pwm_out(pwm_out), .irq(irq)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] d);
    ctl_wr = 1'b1;
    ctl_wdata = d;
    @(negedge clk);
    ctl_wr = 1'b0;
  endtask

  task automatic wait_count(input int c);
    do @(negedge clk); while (count != c[W-1:0]);
  endtask

  task automatic settle();
    wait_count(0);
    wait_count(0);
  endtask

  task automatic t_reset();
    chk("R5 reset ctl", ctl_rdata, 0);
    chk("R5 reset out", pwm_out, 0);
    chk("R1 reset count", count, 0);
    wr(8'h3A);
    chk("R5 readback", ctl_rdata, 8'h3A);
  endtask

  task automatic t_counter();
    int prev;
    cnt_en = 1'b1;
    @(negedge clk);
    prev = count;
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      chk("R1 step", count, (prev + 1) % 4);
      prev = count;
    end
    cnt_en = 1'b0;
    repeat (3) @(negedge clk);
    chk("R1 hold", count, prev);
    cnt_en = 1'b1;
  endtask

  task automatic t_normal();
    settle();
    chk("R2 c0", pwm_out, 1);
    wait_count(1); chk("R2 c1", pwm_out, 1);
    wait_count(2); chk("R2 c2", pwm_out, 0);
    wait_count(3); chk("R2 c3", pwm_out, 0);
    wr(8'h36);
    settle();
    chk("R2 inv c0", pwm_out, 0);
    wait_count(2); chk("R2 inv c2", pwm_out, 1);
    wr(8'h3A);
    settle();
  endtask

  task automatic t_coincide();
    int p0;
    cmp_val = 8'd0;
    settle();
    p0 = pwm_out;
    wait_count(2); chk("R3 hold in period", pwm_out, p0);
    wait_count(0); chk("R3 invert at wrap", pwm_out, 1 - p0);
    wait_count(3); chk("R3 hold in period2", pwm_out, 1 - p0);
    wait_count(0); chk("R3 invert again", pwm_out, p0);
    cmp_val = 8'd2;
    settle();
  endtask

  task automatic t_zero_duty();
    int hi = 0;
    wait_count(0);
    wr(8'h38);
    wait_count(2); chk("R4 compare low", pwm_out, 0);
    wait_count(0); chk("R4 no toggle", pwm_out, 0);
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      hi += pwm_out;
    end
    chk("R4 zero duty", hi, 0);
    wait_count(1);
    wr(8'h3A);
    wait_count(0); chk("R4 resume toggle", pwm_out, 1);
    wait_count(2); chk("R4 resume compare", pwm_out, 0);
  endtask

  task automatic t_full_duty();
    int hi = 0;
    wait_count(0);
    wr(8'h3B);
    wait_count(2); chk("R8 compare still acts", pwm_out, 0);
    wait_count(0); chk("R6 entry active", pwm_out, 1);
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      hi += pwm_out;
    end
    chk("R6 full duty", hi, 8);
    wr(8'h33);
    chk("R9 disconnected", pwm_out, 0);
    wr(8'h3B);
    chk("R9 reconnected", pwm_out, 1);
  endtask

  task automatic t_exit_max();
    wait_count(0);
    wr(8'h3A);
    wait_count(2); chk("R8 compare still blocked", pwm_out, 1);
    wait_count(0); chk("R7 first wrap no toggle", pwm_out, 1);
    wait_count(2); chk("R7 compare back", pwm_out, 0);
    wait_count(0); chk("R7 toggle back", pwm_out, 1);
  endtask

  task automatic t_flag();
    cnt_en = 1'b0;
    @(negedge clk);
    chk("R10 flag set", ctl_rdata[7], 1);
    chk("R11 irq masked", irq, 0);
    wr(8'h7A);
    chk("R10 no clear without read", ctl_rdata[7], 1);
    chk("R11 irq on", irq, 1);
    ctl_rd = 1'b1;
    @(negedge clk);
    ctl_rd = 1'b0;
    wr(8'h7A);
    chk("R10 cleared", ctl_rdata[7], 0);
    chk("R11 irq off", irq, 0);
    wr(8'hFA);
    chk("R10 write one ignored", ctl_rdata[7], 0);
    cnt_en = 1'b1;
    repeat (4) @(negedge clk);
    chk("R10 set by event", ctl_rdata[7], 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_counter();
    t_normal();
    t_coincide();
    t_zero_duty();
    t_full_duty();
    t_exit_max();
    t_flag();
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog act=0 exp=1");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule